// File: doc/BRIEF.md
# Serial Wiper Controller with Twenty-Shot Fuse Store

This block is the digital heart of a 10-bit programmable resistor. A host sends 16-bit command words over a four-wire serial slave port: a clock, an active-low frame select, a data input and a data output. The block keeps the 10-bit tap code that positions the resistor wiper. A small one-time store of twenty slots can freeze the current tap permanently, and a busy/ready line tells the host how long each command takes. All serial inputs are brought into the system clock domain through synchronizers. The fuse array is modelled as a register bank, and all busy times are counted in system clock cycles.

A command word holds two zero bits at the top, then a 4-bit operation, then a 10-bit argument. The host can change the tap any number of times. It then sets the programming enable and burns the value into the next free slot. After power-up, a software reset command or a pulse on the hardware reload pin, the tap is taken from the most recently burnt slot, or from mid-scale if no slot has ever been burnt. The tap code and the content of any slot can be read back: the value is shifted out during the next frame.

Top module: `wpot_ctrl`

## Requirements
- R1: A frame with exactly 16 bits, top bits [15:14] zero, operation [13:10] = 1 and unlocked writes sets the tap to bits [9:0]. The tap changes only through an accepted write or a reload.
- R2: A write frame (operation 1) received while the unlock bit is clear leaves the tap unchanged.
- R3: A frame whose bit count is not 16, or whose bits [15:14] are not zero, is dropped. It starts no busy period and changes no state.
- R4: An accepted command drives rdy low for an exact number of clock cycles: T_PROG for an enabled burn, T_MRD for a slot read, T_RST for a software reset, and T_WR for every other operation.
- R5: Operation 3, with programming enabled and a slot free, stores the current tap in the next free slot (slot 0 first).
- R6: At most 20 slots are ever used. A burn that arrives with all slots used changes nothing and is busy for T_WR.
- R7: A synchronous reset, operation 5 or a falling edge on reload_n loads the tap from the latest used slot, or 0x200 if none is used, and holds rdy low for T_RST cycles. After rst the fuse bank is blank.
- R8: Operation 2 latches {6'b0, tap}. The next 16-bit frame shifts this word out on sdo MSB first, changing after rising sclk edges.
- R9: Operation 4 latches {6'b0, slot content} for the slot number in bits [4:0]. An unused or nonexistent slot returns 0. The word is shifted out during the next frame.
- R10: sdo_oe is high while the frame select is low and low while it is high.
- R11: A frame completed while rdy is low is ignored.
- R12: Operation 0 and operations 7 to 15 start no busy period and change no state.
- R13: Operation 6 sets the unlock flag from bit [1] and the programming enable from bit [0]. Any reload clears both. A burn with the enable clear stores nothing and is busy for T_WR.
- R14: When a reload edge and a frame end reach the controller in the same cycle, the reload is performed and the frame is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sclk | input | 1 | Serial clock from host |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in, sampled on falling sclk |
| reload_n | input | 1 | Active-low hardware reload request (edge-detected) |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for sdo (high-impedance when low) |
| rdy | output | 1 | High when ready, low while a command is busy |
| tap | output | 10 | Current wiper tap code |

## Verification
Two events can collide in one cycle: the end of a frame and a hardware reload. Both inputs pass through synchronizer and edge-detect chains of equal depth. The bench raises the frame select and drops reload_n on the same clock edge, so both events reach the controller together. The frame carries a write to a new tap while writes are unlocked. The check passes only if the tap afterwards equals the latest burnt slot and rdy goes low for the reload.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
  localparam int FRAME_W = 16;
  localparam int OP_LSB  = 10;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_WRITE = 4'd1,
    OP_READW = 4'd2,
    OP_PROG  = 4'd3,
    OP_READM = 4'd4,
    OP_RESET = 4'd5,
    OP_CTRL  = 4'd6
  } op_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wpot_spi_port.sv
module wpot_spi_port #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          sync_n,
  input  logic          din,
  input  logic [FW-1:0] tx_word,
  output logic          frame_end,
  output logic          frame_full,
  output logic [FW-1:0] frame_word,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FW + 1);

  logic [2:0]       sclk_q, sync_q;
  logic [1:0]       din_q;
  logic [CNT_W-1:0] nbits;
  logic [FW-1:0]    tx_sh;
  logic             sel, sclk_fall, sclk_rise, sel_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      sync_q <= '1;
      din_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      sync_q <= {sync_q[1:0], sync_n};
      din_q  <= {din_q[0], din};
    end
  end

  assign sel       = ~sync_q[1];
  assign sclk_fall = sclk_q[2] & ~sclk_q[1];
  assign sclk_rise = ~sclk_q[2] & sclk_q[1];
  assign sel_start = sync_q[2] & ~sync_q[1];
  assign frame_end = ~sync_q[2] & sync_q[1];
  assign frame_full = (nbits == CNT_W'(FW));

  always_ff @(posedge clk) begin
    if (rst) begin
      nbits      <= '0;
      frame_word <= '0;
      tx_sh      <= '0;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b0;
    end else begin
      sdo_oe <= sel;
      if (sel_start) begin
        nbits <= '0;
        tx_sh <= tx_word;
      end else if (sel) begin
        if (sclk_fall) begin
          frame_word <= {frame_word[FW-2:0], din_q[1]};
          if (nbits != CNT_MAX) nbits <= nbits + 1'b1;
        end
        if (sclk_rise) begin
          sdo   <= tx_sh[FW-1];
          tx_sh <= {tx_sh[FW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/wpot_fuse_bank.sv
module wpot_fuse_bank #(
  parameter int W     = 10,
  parameter int SLOTS = 20,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog,
  input  logic [W-1:0]  prog_data,
  input  logic          rd_en,
  input  logic [CW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  latest,
  output logic [CW-1:0] used,
  output logic          full,
  output logic          any
);
  logic [W-1:0] mem [SLOTS];
  logic [W-1:0] rd_q;
  logic         rd_ok;

  assign full    = (used == CW'(SLOTS));
  assign any     = (used != '0);
  assign rd_data = rd_ok ? rd_q : '0;

  always_ff @(posedge clk) begin
    if (prog && !full) mem[used] <= prog_data;
    if (rd_en && (rd_addr < CW'(SLOTS))) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used   <= '0;
      latest <= '0;
      rd_ok  <= 1'b0;
    end else begin
      if (prog && !full) begin
        used   <= used + 1'b1;
        latest <= prog_data;
      end
      if (rd_en) rd_ok <= (rd_addr < used);
    end
  end
endmodule

// File: rtl/wpot_busy_timer.sv
module wpot_busy_timer #(
  parameter int W       = 8,
  parameter int RST_LEN = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         busy
);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      left <= W'(RST_LEN - 1);
    end else if (load) begin
      busy <= 1'b1;
      left <= len - 1'b1;
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/wpot_ctrl.sv
module wpot_ctrl
  import wpot_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SLOTS  = 20,
  parameter int T_WR   = 41,
  parameter int T_PROG = 800000,
  parameter int T_MRD  = 130000,
  parameter int T_RST  = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              din,
  input  logic              reload_n,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              rdy,
  output logic [CODE_W-1:0] tap
);
  localparam int CW   = $clog2(SLOTS + 1);
  localparam int BW   = $clog2(imax(imax(T_WR, T_PROG), imax(T_MRD, T_RST)) + 1);
  localparam int PADW = FRAME_W - CODE_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic               frame_end, frame_full;
  logic [FRAME_W-1:0] frame_word, rd_word;
  logic [2:0]         rl_q;
  logic               reload_go, legal, acc, soft_go, prog_ok;
  logic [OP_W-1:0]    op;
  logic               unlock, prog_en, pend_mem, busy;
  logic [CODE_W-1:0]  fuse_q, fuse_latest;
  logic [CW-1:0]      used;
  logic               full, any;
  logic [BW-1:0]      len;

  wpot_spi_port #(.FW(FRAME_W)) u_port (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .din(din),
    .tx_word(rd_word), .frame_end(frame_end), .frame_full(frame_full),
    .frame_word(frame_word), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) rl_q <= '1;
    else     rl_q <= {rl_q[1:0], reload_n};
  end
  assign reload_go = rl_q[2] & ~rl_q[1];

  assign op      = frame_word[OP_LSB +: OP_W];
  assign legal   = frame_end && frame_full && (frame_word[FRAME_W-1:OP_LSB+OP_W] == '0);
  assign acc     = legal && !busy && !reload_go && (op != OP_NOP) && (op <= OP_CTRL);
  assign soft_go = acc && (op == OP_RESET);
  assign prog_ok = prog_en && !full;

  wpot_fuse_bank #(.W(CODE_W), .SLOTS(SLOTS), .CW(CW)) u_fuse (
    .clk(clk), .rst(rst),
    .prog(acc && (op == OP_PROG) && prog_ok), .prog_data(tap),
    .rd_en(acc && (op == OP_READM)), .rd_addr(frame_word[CW-1:0]),
    .rd_data(fuse_q), .latest(fuse_latest), .used(used), .full(full), .any(any)
  );

  always_comb begin
    if (reload_go || soft_go)                len = BW'(T_RST);
    else if (op == OP_READM)                 len = BW'(T_MRD);
    else if ((op == OP_PROG) && prog_ok)     len = BW'(T_PROG);
    else                                     len = BW'(T_WR);
  end

  wpot_busy_timer #(.W(BW), .RST_LEN(T_RST)) u_timer (
    .clk(clk), .rst(rst), .load(acc || reload_go), .len(len), .busy(busy)
  );
  assign rdy = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap      <= MID;
      unlock   <= 1'b0;
      prog_en  <= 1'b0;
      pend_mem <= 1'b0;
      rd_word  <= '0;
    end else begin
      pend_mem <= 1'b0;
      if (reload_go || soft_go) begin
        tap     <= any ? fuse_latest : MID;
        unlock  <= 1'b0;
        prog_en <= 1'b0;
      end else if (acc) begin
        case (op)
          OP_WRITE: if (unlock) tap <= frame_word[CODE_W-1:0];
          OP_READW: rd_word  <= {{PADW{1'b0}}, tap};
          OP_READM: pend_mem <= 1'b1;
          OP_CTRL: begin
            unlock  <= frame_word[1];
            prog_en <= frame_word[0];
          end
          default: ;
        endcase
      end
      if (pend_mem) rd_word <= {{PADW{1'b0}}, fuse_q};
    end
  end
endmodule

// File: rtl/wpot_ctrl_chk.sv
module wpot_ctrl_chk #(
  parameter int CODE_W = 10,
  parameter int SLOTS  = 20,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_n,
  input logic              rdy,
  input logic              sdo_oe,
  input logic [CODE_W-1:0] tap,
  input logic              acc,
  input logic              reload_go,
  input logic [3:0]        op,
  input logic              unlock,
  input logic [CW-1:0]     used
);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!acc && !reload_go) |=> $stable(tap));

  p_locked_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && (op == 4'd1) && !unlock) |=> $stable(tap));

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (rdy && !acc && !reload_go) |=> rdy);

  p_busy_r4: assert property (@(posedge clk) disable iff (rst)
    acc |=> !rdy);

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (used == $past(used)) || (used == $past(used) + 1'b1));

  p_cap_r6: assert property (@(posedge clk) disable iff (rst)
    used <= CW'(SLOTS));

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    reload_go |=> !rdy);

  p_oe_r10: assert property (@(posedge clk) disable iff (rst)
    (sync_n && $past(sync_n) && $past(sync_n, 2) && $past(sync_n, 3)) |-> !sdo_oe);

  p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (!rdy && !reload_go) |=> $stable(tap));
endmodule

bind wpot_ctrl wpot_ctrl_chk #(.CODE_W(CODE_W), .SLOTS(SLOTS), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .sync_n(sync_n), .rdy(rdy), .sdo_oe(sdo_oe), .tap(tap),
  .acc(acc), .reload_go(reload_go), .op(op), .unlock(unlock), .used(used)
);

// File: tb/test_wpot_ctrl.sv
`timescale 1ns/1ps
module test_wpot_ctrl;
  localparam int T_WR = 6, T_PROG = 400, T_MRD = 300, T_RST = 30, HALF = 8;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sync_n = 1'b1, din = 1'b0, reload_n = 1'b1;
  logic sdo, sdo_oe, rdy;
  logic [9:0] tap;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  wpot_ctrl #(.T_WR(T_WR), .T_PROG(T_PROG), .T_MRD(T_MRD), .T_RST(T_RST)) i_wpot_ctrl (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .din(din), .reload_n(reload_n),
    .sdo(sdo), .sdo_oe(sdo_oe), .rdy(rdy), .tap(tap)
  );

  typedef struct { bit cmp; logic [15:0] val; string req; } exp_t;
  exp_t q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fw(input logic [3:0] op, input logic [9:0] d);
    return {2'b00, op, d};
  endfunction

  task automatic spi(input logic [15:0] w, input int n, input bit cmp,
                     input logic [15:0] ev, input string req, input bit rl);
    exp_t e;
    if (n == 16) begin
      e.cmp = cmp; e.val = ev; e.req = req;
      q.push_back(e);
    end
    @(negedge clk); sync_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      din = w[15-i]; sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sync_n = 1'b1;
    if (rl) begin
      reload_n = 1'b0;
      repeat (4) @(negedge clk);
      reload_n = 1'b1;
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [9:0] d);
    spi(fw(op, d), 16, 1'b0, 16'h0, "", 1'b0);
  endtask

  task automatic busy_len(input int ev, input string req);
    int n = 0;
    int w = 0;
    while (rdy && w < 12) begin @(negedge clk); w++; end
    while (!rdy && n < 100000) begin n++; @(negedge clk); end
    chk(req, n, ev);
  endtask

  task automatic wait_ready();
    repeat (8) @(negedge clk);
    while (!rdy) @(negedge clk);
  endtask

  // Scoreboard monitor: collects sdo per frame and compares with queued expectation
  logic [15:0] cap = '0;
  int nb = 0;
  always @(negedge sclk or posedge sync_n) begin
    if (sync_n) begin
      if (nb == 16 && q.size() > 0) begin
        exp_t e = q.pop_front();
        if (e.cmp) chk(e.req, {16'h0, cap}, {16'h0, e.val});
      end
      nb = 0;
    end else begin
      if (nb == 0) chk("R10 oe during frame", {31'h0, sdo_oe}, 32'h1);
      cap = {cap[14:0], sdo};
      nb++;
    end
  end

  function automatic logic [9:0] val(input int i);
    return 10'((i * 37 + 1) & 10'h3FF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R7 reset rdy low", {31'h0, rdy}, 32'h0);
    chk("R7 reset tap mid", {22'h0, tap}, 32'h200);
    chk("R10 reset oe low", {31'h0, sdo_oe}, 32'h0);
    rst = 1'b0;
    begin
      int n = 0;
      while (!rdy && n < 1000) begin n++; @(negedge clk); end
      chk("R7 restore ends", {31'h0, (n > 0 && n <= T_RST)}, 32'h1);
    end

    // R2: write while locked
    cmd(4'd1, 10'h155); busy_len(T_WR, "R4 write busy");
    chk("R2 locked write ignored", {22'h0, tap}, 32'h200);

    // R13: burn with enable clear stores nothing
    cmd(4'd6, 10'h2); wait_ready();
    cmd(4'd3, 10'h0); busy_len(T_WR, "R13 disabled burn short busy");
    cmd(4'd4, 10'h0); wait_ready();
    spi(fw(4'd0, 0), 16, 1'b1, 16'h0000, "R13 disabled burn slot0 empty", 1'b0);

    cmd(4'd6, 10'h3); wait_ready();
    cmd(4'd1, 10'h155); busy_len(T_WR, "R4 write busy unlocked");
    chk("R1 write sets tap", {22'h0, tap}, 32'h155);

    // R3: short frame and bad top bits
    spi(fw(4'd1, 10'h0AA), 15, 1'b0, 16'h0, "", 1'b0); busy_len(0, "R3 short frame no busy");
    chk("R3 short frame no effect", {22'h0, tap}, 32'h155);
    spi({2'b01, 4'd1, 10'h0AA}, 16, 1'b0, 16'h0, "", 1'b0); busy_len(0, "R3 top bits no busy");
    chk("R3 top bits no effect", {22'h0, tap}, 32'h155);

    // R12: undefined and no-op
    cmd(4'd7, 10'h0AA); busy_len(0, "R12 op7 no busy");
    cmd(4'd15, 10'h0AA); busy_len(0, "R12 op15 no busy");
    cmd(4'd0, 10'h0AA); busy_len(0, "R12 nop no busy");
    chk("R12 tap unchanged", {22'h0, tap}, 32'h155);

    // R8: wiper readback
    cmd(4'd2, 10'h0); wait_ready();
    spi(fw(4'd0, 0), 16, 1'b1, 16'h0155, "R8 tap readback", 1'b0);
    repeat (8) @(negedge clk);
    chk("R10 oe low after frame", {31'h0, sdo_oe}, 32'h0);

    // R5 burn, R11 write during busy ignored
    cmd(4'd3, 10'h0);
    cmd(4'd1, 10'h0F0);
    chk("R11 still busy after write frame", {31'h0, rdy}, 32'h0);
    wait_ready();
    chk("R11 write during busy ignored", {22'h0, tap}, 32'h155);
    cmd(4'd4, 10'h0); busy_len(T_MRD, "R4 slot read busy");
    spi(fw(4'd0, 0), 16, 1'b1, 16'h0155, "R5 slot0 holds burnt tap", 1'b0);
    cmd(4'd4, 10'h5); wait_ready();
    spi(fw(4'd0, 0), 16, 1'b1, 16'h0000, "R9 unused slot reads zero", 1'b0);
    cmd(4'd4, 10'd25); wait_ready();
    spi(fw(4'd0, 0), 16, 1'b1, 16'h0000, "R9 out of range slot reads zero", 1'b0);

    // R7 soft reset, R13 flags cleared
    cmd(4'd1, 10'h0F0); wait_ready();
    cmd(4'd5, 10'h0); busy_len(T_RST, "R4 soft reset busy");
    chk("R7 soft reset reloads", {22'h0, tap}, 32'h155);
    cmd(4'd1, 10'h111); wait_ready();
    chk("R13 reload clears unlock", {22'h0, tap}, 32'h155);

    // R6: fill remaining 19 slots, 21st burn ignored
    cmd(4'd6, 10'h3); wait_ready();
    for (int i = 1; i < 20; i++) begin
      cmd(4'd1, val(i)); wait_ready();
      cmd(4'd3, 10'h0);
      if (i == 1) busy_len(T_PROG, "R4 burn busy"); else wait_ready();
    end
    cmd(4'd1, 10'h2AB); wait_ready();
    cmd(4'd3, 10'h0); busy_len(T_WR, "R6 full burn short busy");
    cmd(4'd4, 10'd19); wait_ready();
    spi(fw(4'd0, 0), 16, 1'b1, {6'h0, val(19)}, "R6 slot19 kept", 1'b0);
    cmd(4'd4, 10'd1); wait_ready();
    spi(fw(4'd0, 0), 16, 1'b1, {6'h0, val(1)}, "R9 slot1 readback", 1'b0);
    @(negedge clk); reload_n = 1'b0;
    repeat (4) @(negedge clk); reload_n = 1'b1;
    chk("R7 pin reload busy", {31'h0, rdy}, 32'h0);
    wait_ready();
    chk("R7 pin reload latest slot", {22'h0, tap}, {22'h0, val(19)});

    // R14: reload edge and frame end together
    cmd(4'd6, 10'h2); wait_ready();
    spi(fw(4'd1, 10'h0F0), 16, 1'b0, 16'h0, "", 1'b1);
    chk("R14 reload busy", {31'h0, rdy}, 32'h0);
    wait_ready();
    chk("R14 reload wins over write", {22'h0, tap}, {22'h0, val(19)});

    // power-on reset blanks the bank
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    chk("R7 power-on blank mid", {22'h0, tap}, 32'h200);
    wait_ready();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule